// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block sits at the receive end of a serial video link and judges a self-test. Once per pixel clock it may accept a 24-bit payload word. While the test-enable level is high, it compares each word against a locally generated PRBS7 stream (x^7 + x^6 + 1). It does not need a known starting point, because it takes its generator state from the first word it receives. Any word that differs from the expected continuation counts as one errored payload. It does not matter how many of the 24 bits are wrong.

The checker drives a single PASS line that has two reporting styles. In the per-error style, PASS dips low for the second half of the clock cycle that follows each errored payload. In the verdict-only style, PASS stays high during the test. In both styles, once the enable falls, PASS carries a sticky result: high for a clean run, low if anything failed. It keeps that value until a new test or a reset. A 16-bit saturating error count is also provided. A blanking signal tells the normal video path to mute its outputs while a test is running.

Top module: `prbs7_link_checker`

## Requirements
- R1: After reset, pass_o is 1, blank_o is 0 and err_cnt_o is 0.
- R2: The stream uses x^7 + x^6 + 1, and payload bit 23 is the earliest bit in time. The first payload accepted after a test starts is not compared. Its bits [6:0] become the generator state, with bit 0 the newest. Every later accepted payload is compared with the next 24 stream bits, so a clean stream from any non-zero state gives err_cnt_o = 0.
- R3: A compared payload with any number of wrong bits, from 1 to 24, adds exactly one to err_cnt_o.
- R4: Cycles with pay_vld_i low do not advance the expected stream and are never counted as errors.
- R5: With every_err_mode_i = 1, pass_o is low during the low half of the clock cycle that follows the edge that accepted an errored payload. It is high during the high half of that same cycle.
- R6: With every_err_mode_i = 0, pass_o stays 1 throughout an active test, including after errored payloads.
- R7: From the first edge at which test_en_i is low, pass_o shows the verdict: 1 if the test saw no errored payload, 0 otherwise. While test_en_i stays low, payloads are ignored, and pass_o and err_cnt_o hold their values.
- R8: A rising test_en_i clears err_cnt_o and the verdict, and it re-arms seeding. If a payload is valid in that first cycle, that payload is the seed.
- R9: err_cnt_o saturates at 2^CNT_W - 1 and does not wrap.
- R10: blank_o is 1 in the cycle after every edge at which test_en_i is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| test_en_i | input | 1 | Test runs while high |
| every_err_mode_i | input | 1 | 1: pulse PASS on each errored payload; 0: verdict only |
| pay_vld_i | input | 1 | Payload valid strobe |
| pay_i | input | WORD_W | Received payload word |
| pass_o | output | 1 | PASS indication |
| err_cnt_o | output | CNT_W | Saturating errored-payload count |
| blank_o | output | 1 | Mute request for the normal video outputs |

## Verification
Saturation of the counter and the per-error PASS dip can fall in the same cycle. To provoke this, the bench drives more errored payloads than the counter can hold, with the per-error style selected. On the last errored payload, the bench checks two things together: the count holds at its maximum, and PASS still dips in the low phase of the following cycle. A second coincidence is checked the same way: an errored payload in the final active cycle, followed directly by the enable falling. That run must produce the pulse first and then a low verdict on the next edge.

// File: rtl/prbs7_chk_pkg.sv
package prbs7_chk_pkg;
  // Generator order and feedback tap positions (state bit 0 is newest).
  localparam int unsigned LFSR_LEN = 7;
  localparam int unsigned TAP_HI   = 6;  // x^7 term
  localparam int unsigned TAP_LO   = 5;  // x^6 term
  typedef logic [LFSR_LEN-1:0] lfsr_t;
endpackage

// File: rtl/prbs7_ref_gen.sv
module prbs7_ref_gen
  import prbs7_chk_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              take_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] exp_o,
  output logic              armed_o
);
  lfsr_t state_q;
  lfsr_t state_nxt;
  logic  armed_q;

  // Unrolled generator: WORD_W serial steps per cycle, earliest bit to MSB.
  always_comb begin
    lfsr_t s;
    logic  nb;
    s     = state_q;
    exp_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nb                = s[TAP_HI] ^ s[TAP_LO];
      exp_o[WORD_W-1-i] = nb;
      s                 = {s[LFSR_LEN-2:0], nb};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      armed_q <= take_i;
      state_q <= take_i ? word_i[LFSR_LEN-1:0] : '0;
    end else if (take_i) begin
      armed_q <= 1'b1;
      state_q <= armed_q ? state_nxt : word_i[LFSR_LEN-1:0];
    end
  end

  assign armed_o = armed_q;

  AST_SEED_REARM: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !take_i) |=> !armed_o); // R8
  AST_SEED_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
    take_i |=> armed_o); // R2
endmodule

// File: rtl/prbs7_err_tally.sv
module prbs7_err_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             errored_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= errored_i;
      if (start_i)
        cnt_q <= '0;
      else if (errored_i && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_o == CNT_MAX && !start_i) |=> cnt_o == CNT_MAX); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !start_i |=> (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R3
  AST_IDLE_CNT: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cnt_o)); // R7
  AST_START_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> cnt_o == '0); // R8
endmodule

// File: rtl/prbs7_verdict.sv
module prbs7_verdict (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic en_i,
  input  logic errored_i,
  input  logic err_q_i,
  input  logic mode_i,
  output logic pass_o
);
  logic verdict_q;
  logic pass_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      verdict_q <= 1'b1;
      pass_q    <= 1'b1;
    end else if (start_i) begin
      verdict_q <= 1'b1;
      pass_q    <= 1'b1;
    end else begin
      if (errored_i) verdict_q <= 1'b0;
      pass_q <= en_i ? 1'b1 : verdict_q;
    end
  end

  // Dip for the low clock phase of the cycle after an errored payload.
  assign pass_o = pass_q & ~(err_q_i & mode_i & ~clk_i);

  AST_VERDICT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !start_i && !errored_i && !$past(en_i)) |=> $stable(pass_q)); // R7
  AST_ACTIVE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> pass_q); // R6
endmodule

// File: rtl/prbs7_link_checker.sv
module prbs7_link_checker
  import prbs7_chk_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              test_en_i,
  input  logic              every_err_mode_i,
  input  logic              pay_vld_i,
  input  logic [WORD_W-1:0] pay_i,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic              blank_o
);
  logic              en_q;
  logic              start;
  logic              take;
  logic              armed;
  logic              errored;
  logic              err_q;
  logic [WORD_W-1:0] exp_word;

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= test_en_i;
  end

  assign start   = test_en_i & ~en_q;
  assign take    = test_en_i & pay_vld_i;
  assign errored = take & armed & ~start & (pay_i != exp_word);
  assign blank_o = en_q;

  prbs7_ref_gen #(.WORD_W(WORD_W)) i_ref (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .take_i(take),
    .word_i(pay_i), .exp_o(exp_word), .armed_o(armed)
  );

  prbs7_err_tally #(.CNT_W(CNT_W)) i_tally (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .en_i(test_en_i),
    .errored_i(errored), .cnt_o(err_cnt_o), .err_o(err_q)
  );

  prbs7_verdict i_verdict (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .en_i(test_en_i),
    .errored_i(errored), .err_q_i(err_q), .mode_i(every_err_mode_i),
    .pass_o(pass_o)
  );

  AST_ERR_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |-> blank_o); // R10
  AST_NO_ERR_INVALID: assert property (@(posedge clk_i) disable iff (rst_i)
    !pay_vld_i |=> !err_q); // R4
endmodule

// File: tb/test_prbs7_link_checker.sv
module test_prbs7_link_checker;
  localparam int W = 24;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, mode = 1'b0, vld = 1'b0;
  logic [W-1:0] pl = '0;
  logic pass, blank;
  logic [CW-1:0] cnt;
  int n_chk = 0, n_fail = 0;
  logic [6:0] st;
  logic [W-1:0] w;

  always #2.5 clk = ~clk;

  prbs7_link_checker #(.WORD_W(W), .CNT_W(CW)) i_prbs7_link_checker (
    .clk_i(clk), .rst_i(rst), .test_en_i(en), .every_err_mode_i(mode),
    .pay_vld_i(vld), .pay_i(pl), .pass_o(pass), .err_cnt_o(cnt), .blank_o(blank)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Next 24 bits of x^7+x^6+1, earliest bit in bit 23, state bit 0 newest.
  task automatic next_w(inout logic [6:0] s, output logic [W-1:0] o);
    logic nb;
    for (int i = 0; i < W; i++) begin
      nb = s[6] ^ s[5];
      o[W-1-i] = nb;
      s = {s[5:0], nb};
    end
  endtask

  // Present inputs, let one edge take them, return at edge + 1 ns.
  task automatic drive(input logic e, input logic v, input logic [W-1:0] d);
    en = e; vld = v; pl = d;
    @(posedge clk); #1;
  endtask

  // Check PASS in both phases of the current cycle, no payload offered.
  task automatic phase_chk(input logic exp_hi, input logic exp_lo, input string tag);
    vld = 1'b0;
    check(pass === exp_hi, {tag, " high phase"}, pass, exp_hi);
    #2.5;
    check(pass === exp_lo, {tag, " low phase"}, pass, exp_lo);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check(pass === 1'b1, "R1 pass", pass, 1);
    check(blank === 1'b0, "R1 blank", blank, 0);
    check(cnt === '0, "R1 count", cnt, 0);

    // R2 / R4 clean runs from every non-zero state, gaps on odd states
    for (int s = 1; s < 128; s++) begin
      st = 7'(s);
      mode = s[1];
      for (int k = 0; k < 5; k++) begin
        next_w(st, w);
        drive(1'b1, 1'b1, w);
        if (s[0]) drive(1'b1, 1'b0, ~w); // R4 gap with garbage
      end
      check(blank === 1'b1, "R10 blank active", blank, 1);
      check(cnt === '0, "R2 clean count", cnt, 0);
      drive(1'b0, 1'b0, '0);
      check(pass === 1'b1, "R7 clean verdict", pass, 1);
      check(blank === 1'b0, "R10 blank idle", blank, 0);
    end

    // R3 / R5 / R6 one errored payload of each weight 1..24
    for (int k = 1; k <= W; k++) begin
      mode = k[0];
      st = 7'(k * 5 + 1);
      next_w(st, w); drive(1'b1, 1'b1, w);      // seed, R8
      check(cnt === '0, "R8 count cleared", cnt, 0);
      check(pass === 1'b1, "R8 pass restored", pass, 1);
      next_w(st, w); drive(1'b1, 1'b1, w);
      next_w(st, w);
      drive(1'b1, 1'b1, w ^ W'((64'd1 << k) - 1));
      if (mode) phase_chk(1'b1, 1'b0, "R5 pulse");
      else      phase_chk(1'b1, 1'b1, "R6 no pulse");
      next_w(st, w); drive(1'b1, 1'b1, w);
      check(cnt === 16'd1, "R3 one per payload", cnt, 1);
      check(pass === 1'b1, "R6 pass during test", pass, 1);
      drive(1'b0, 1'b0, '0);
      check(pass === 1'b0, "R7 fail verdict", pass, 0);
      for (int j = 0; j < 3; j++) drive(1'b0, 1'b1, W'(j * 77));
      check(pass === 1'b0, "R7 verdict held", pass, 0);
      check(cnt === 16'd1, "R7 count held", cnt, 1);
    end

    // Error in last active cycle, enable falls next cycle
    mode = 1'b1;
    st = 7'h3A;
    next_w(st, w); drive(1'b1, 1'b1, w);
    next_w(st, w); drive(1'b1, 1'b1, ~w);
    en = 1'b0;
    check(pass === 1'b1, "R5 last-cycle high phase", pass, 1);
    #2.5;
    check(pass === 1'b0, "R5 last-cycle low phase", pass, 0);
    @(posedge clk); #1;
    check(pass === 1'b0, "R7 verdict after last error", pass, 0);

    // R9 saturation with pulse on the final errored payload
    st = 7'h11;
    next_w(st, w); drive(1'b1, 1'b1, w);
    for (int i = 0; i < 65540; i++) begin
      next_w(st, w);
      drive(1'b1, 1'b1, w ^ 24'h1);
    end
    check(cnt === 16'hFFFF, "R9 saturated", cnt, 65535);
    phase_chk(1'b1, 1'b0, "R5 pulse at saturation");
    check(cnt === 16'hFFFF, "R9 no wrap", cnt, 65535);
    drive(1'b0, 1'b0, '0);
    check(pass === 1'b0, "R7 verdict after saturation", pass, 0);

    // R1 reset clears held verdict
    rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    check(pass === 1'b1, "R1 pass after reset", pass, 1);
    check(cnt === '0, "R1 count after reset", cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule